// File: doc/BRIEF.md
# LIN frame decoder

This block listens to a single-wire LIN bus line and turns the bit stream into decoded frames. A frame opens with a long dominant (low) break, followed by a synchronisation byte, a protected identifier byte, one to eight response data bytes and a checksum byte. Every byte travels as eight data bits, least significant first, between one low start bit and one high stop bit, with no parity bit. The decoder samples each bit at the middle of its period. The period is given in clock cycles on an input, because the rate is known in advance and is not measured.

The host supplies the expected response length and picks the checksum flavour. In classic mode the checksum covers only the data bytes. In enhanced mode it also covers the protected identifier byte. The decoder reports one outcome per frame: a valid strobe, or one of three distinct error strobes for a bad sync byte, a bad identifier parity or a bad checksum. It also raises trigger pulses when the identifier, the data, or both match host-supplied patterns. This makes it suitable as a bus monitor or as the front end of a response handler.

Top module: `lin_frame_decoder`

## Requirements
- R1: After reset all outputs are zero and no strobe or trigger is raised until a frame is decoded.
- R2: A frame starts only after the line has stayed low for at least 13 bit periods, then returned high. A low of 10 bit periods is not a break, and bytes that are not preceded by a break produce no strobe or trigger.
- R3: Each byte is received as one low start bit, eight data bits least significant first and one high stop bit. Bits are sampled near mid-period, and `bit_period` gives the period in clock cycles.
- R4: If the first byte after a break is not 0x55, `err_sync` pulses and the rest of the frame is ignored.
- R5: The identifier byte carries the ID in bits 5:0. Bit 6 must equal ID0^ID1^ID2^ID4, and bit 7 must equal the inverse of ID1^ID3^ID4^ID5. On a mismatch `err_parity` pulses, the frame is dropped and `frame_id` keeps its previous value. Otherwise `frame_id` takes the new ID.
- R6: The response holds `exp_len` data bytes, where 0 is taken as 1 and values above 8 are taken as 8. At the end of the frame, data byte k appears in `frame_data` bits 8k+7:8k, unused bytes read as zero, and `byte_count` gives the length.
- R7: In classic mode (`enhanced_mode`=0), the expected checksum is the bitwise inverse of the 8-bit sum of the data bytes, with each carry out added back into bit 0.
- R8: In enhanced mode (`enhanced_mode`=1), the same end-around sum is also taken over the full 8-bit protected identifier byte.
- R9: When the received checksum differs from the expected one, `err_checksum` pulses and `frame_valid` stays low. `frame_data` and `byte_count` are still updated.
- R10: `trig_id` pulses once per frame, right after a parity-correct identifier whose 6-bit ID equals `match_id`, whatever the frame's later outcome.
- R11: `trig_data` pulses together with `frame_valid` when the first `byte_count` data bytes equal the same bytes of `match_data`. `trig_both` pulses when, in addition, that frame raised `trig_id`.
- R12: All strobes last one cycle, and a frame raises at most one of `frame_valid`, `err_sync`, `err_parity` and `err_checksum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial bus line, low is dominant |
| bit_period | input | CNT_W | Bit period in clock cycles (at least 2) |
| enhanced_mode | input | 1 | 1 selects the checksum that includes the identifier byte |
| exp_len | input | LEN_W | Expected number of response data bytes |
| match_id | input | 6 | Identifier pattern for `trig_id` |
| match_data | input | 8*MAX_BYTES | Data pattern for `trig_data`, byte k in bits 8k+7:8k |
| frame_id | output | 6 | Last parity-correct identifier |
| frame_data | output | 8*MAX_BYTES | Data bytes of the last completed response |
| byte_count | output | LEN_W | Number of data bytes in `frame_data` |
| frame_valid | output | 1 | Pulse: frame completed with correct checksum |
| err_sync | output | 1 | Pulse: sync byte not 0x55 |
| err_parity | output | 1 | Pulse: identifier parity wrong |
| err_checksum | output | 1 | Pulse: checksum wrong |
| trig_id | output | 1 | Pulse: identifier matched `match_id` |
| trig_data | output | 1 | Pulse: valid frame whose data matched `match_data` |
| trig_both | output | 1 | Pulse: identifier and data both matched |

## Verification
The hardest case to reach is a frame that is correct in every respect except the checksum flavour. The identifier passes parity and every byte is well framed, so only the choice of including the identifier byte decides whether the frame passes. The stimulus reaches it by sometimes building the checksum with the opposite flavour to the one configured. Random data bytes run the end-around carry through many wrap values. Separate directed frames cover a short low that must not count as a break, the length clamps at 0 and above 8, and a data pattern that differs in a single bit.

// File: rtl/lin_frame_decoder.sv
module lin_frame_decoder #(
  parameter int CNT_W     = 16,
  parameter int MAX_BYTES = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic [CNT_W-1:0]  bit_period,
  input  logic              enhanced_mode,
  input  logic [LEN_W-1:0]  exp_len,
  input  logic [5:0]        match_id,
  input  logic [DATA_W-1:0] match_data,
  output logic [5:0]        frame_id,
  output logic [DATA_W-1:0] frame_data,
  output logic [LEN_W-1:0]  byte_count,
  output logic              frame_valid,
  output logic              err_sync,
  output logic              err_parity,
  output logic              err_checksum,
  output logic              trig_id,
  output logic              trig_data,
  output logic              trig_both
);

  localparam int BRK_W = CNT_W + 4;
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DELIM, S_HUNT, S_SHIFT} state_t;
  typedef enum logic [1:0] {F_SYNC, F_PID, F_DATA, F_CHK} field_t;

  state_t            state;
  field_t            field;
  logic              rx_m, rx_s, rx_d;
  logic [BRK_W-1:0]  low_cnt;
  logic [CNT_W-1:0]  tmr;
  logic [3:0]        bitn;
  logic [7:0]        sh;
  logic [7:0]        acc;
  logic [LEN_W-1:0]  cnt;
  logic [DATA_W-1:0] data_r;
  logic              id_hit;

  logic [BRK_W-1:0]  bp_x, brk_len;
  logic              break_det, pid_ok, data_hit;
  logic [LEN_W-1:0]  need;
  logic [DATA_W-1:0] cmp_mask;

  assign bp_x      = BRK_W'(bit_period);
  assign brk_len   = (bp_x << 3) + (bp_x << 2) + bp_x;
  assign break_det = (low_cnt == brk_len);

  assign pid_ok = (sh[6] == (sh[0] ^ sh[1] ^ sh[2] ^ sh[4])) &&
                  (sh[7] == ~(sh[1] ^ sh[3] ^ sh[4] ^ sh[5]));

  always_comb begin
    if (exp_len == '0)                        need = LEN_W'(1);
    else if (exp_len > LEN_W'(MAX_BYTES))     need = LEN_W'(MAX_BYTES);
    else                                      need = exp_len;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_mask
    assign cmp_mask[8*g +: 8] = (LEN_W'(g) < need) ? 8'hFF : 8'h00;
  end

  assign data_hit = ((data_r ^ match_data) & cmp_mask) == '0;

  function automatic logic [7:0] add_eac(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (rx_s) low_cnt <= '0;
    else if (!break_det) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_d <= 1'b1;
      state <= S_IDLE; field <= F_SYNC;
      tmr <= '0; bitn <= '0; sh <= '0; acc <= '0; cnt <= '0;
      data_r <= '0; id_hit <= 1'b0;
      frame_id <= '0; frame_data <= '0; byte_count <= '0;
      frame_valid <= 1'b0; err_sync <= 1'b0; err_parity <= 1'b0; err_checksum <= 1'b0;
      trig_id <= 1'b0; trig_data <= 1'b0; trig_both <= 1'b0;
    end else begin
      rx_m <= rx_line; rx_s <= rx_m; rx_d <= rx_s;
      frame_valid <= 1'b0; err_sync <= 1'b0; err_parity <= 1'b0; err_checksum <= 1'b0;
      trig_id <= 1'b0; trig_data <= 1'b0; trig_both <= 1'b0;
      if (break_det) begin
        state <= S_DELIM;
      end else begin
        case (state)
          S_IDLE: ;
          S_DELIM: if (rx_s) begin
            state <= S_HUNT;
            field <= F_SYNC;
          end
          S_HUNT: if (rx_d && !rx_s) begin
            state <= S_SHIFT;
            tmr   <= bit_period >> 1;
            bitn  <= '0;
          end
          S_SHIFT: begin
            if (tmr != '0) begin
              tmr <= tmr - 1'b1;
            end else begin
              tmr <= bit_period - 1'b1;
              if (bitn == 4'd0) begin
                if (rx_s) state <= S_HUNT;
                else      bitn  <= 4'd1;
              end else if (bitn != 4'd9) begin
                sh   <= {rx_s, sh[7:1]};
                bitn <= bitn + 1'b1;
              end else begin
                state <= S_HUNT;
                case (field)
                  F_SYNC: begin
                    if (rx_s && sh == 8'h55) field <= F_PID;
                    else begin
                      err_sync <= 1'b1;
                      state    <= S_IDLE;
                    end
                  end
                  F_PID: begin
                    if (!rx_s) state <= S_IDLE;
                    else if (!pid_ok) begin
                      err_parity <= 1'b1;
                      state      <= S_IDLE;
                    end else begin
                      frame_id <= sh[5:0];
                      acc      <= enhanced_mode ? sh : 8'h00;
                      data_r   <= '0;
                      cnt      <= '0;
                      id_hit   <= (sh[5:0] == match_id);
                      trig_id  <= (sh[5:0] == match_id);
                      field    <= F_DATA;
                    end
                  end
                  F_DATA: begin
                    if (!rx_s) state <= S_IDLE;
                    else begin
                      data_r[8*cnt[IDX_W-1:0] +: 8] <= sh;
                      acc <= add_eac(acc, sh);
                      cnt <= cnt + 1'b1;
                      if (cnt + 1'b1 == need) field <= F_CHK;
                    end
                  end
                  F_CHK: begin
                    state <= S_IDLE;
                    if (rx_s) begin
                      frame_data <= data_r;
                      byte_count <= cnt;
                      if (sh == ~acc) begin
                        frame_valid <= 1'b1;
                        trig_data   <= data_hit;
                        trig_both   <= data_hit & id_hit;
                      end else begin
                        err_checksum <= 1'b1;
                      end
                    end
                  end
                  default: state <= S_IDLE;
                endcase
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/lin_frame_decoder_chk.sv
module lin_frame_decoder_chk #(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic             err_sync,
  input logic             err_parity,
  input logic             err_checksum,
  input logic             trig_id,
  input logic             trig_data,
  input logic             trig_both,
  input logic [LEN_W-1:0] byte_count
);

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_valid, err_sync, err_parity, err_checksum}));

  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r12_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sync || err_parity || err_checksum) |=> !(err_sync || err_parity || err_checksum));

  a_r11_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trig_data |-> frame_valid);

  a_r11_both_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    trig_both |-> trig_data);

  a_r10_id_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_id |=> !trig_id);

  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (byte_count >= LEN_W'(1) && byte_count <= LEN_W'(MAX_BYTES)));

endmodule

bind lin_frame_decoder lin_frame_decoder_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .err_sync(err_sync),
  .err_parity(err_parity), .err_checksum(err_checksum), .trig_id(trig_id),
  .trig_data(trig_data), .trig_both(trig_both), .byte_count(byte_count));

// File: tb/lin_frame_decoder_bench.sv
module lin_frame_decoder_bench;
  localparam int BP = 12;

  logic clk = 0, rst_n = 0, rx_line = 1, enhanced_mode = 0;
  logic [15:0] bit_period = 16'(BP);
  logic [3:0]  exp_len = 4'd1;
  logic [5:0]  match_id = '0;
  logic [63:0] match_data = '0;
  logic [5:0]  frame_id;
  logic [63:0] frame_data;
  logic [3:0]  byte_count;
  logic frame_valid, err_sync, err_parity, err_checksum, trig_id, trig_data, trig_both;

  int n_chk = 0, n_err = 0;
  int c_val = 0, c_sync = 0, c_par = 0, c_chk = 0, c_tid = 0, c_tdat = 0, c_tboth = 0;
  logic [5:0] last_id = '0;
  bit done = 0;

  always #10 clk = ~clk;

  lin_frame_decoder u_lin_frame_decoder (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_period(bit_period),
    .enhanced_mode(enhanced_mode), .exp_len(exp_len), .match_id(match_id),
    .match_data(match_data), .frame_id(frame_id), .frame_data(frame_data),
    .byte_count(byte_count), .frame_valid(frame_valid), .err_sync(err_sync),
    .err_parity(err_parity), .err_checksum(err_checksum), .trig_id(trig_id),
    .trig_data(trig_data), .trig_both(trig_both));

  always @(negedge clk) if (rst_n) begin
    if (frame_valid)  c_val++;
    if (err_sync)     c_sync++;
    if (err_parity)   c_par++;
    if (err_checksum) c_chk++;
    if (trig_id)      c_tid++;
    if (trig_data)    c_tdat++;
    if (trig_both)    c_tboth++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] ref_sum(input bit enh, input logic [7:0] pid,
                                         input logic [63:0] d, input int n);
    logic [8:0] s;
    logic [7:0] a;
    a = enh ? pid : 8'h00;
    for (int k = 0; k < n; k++) begin
      s = {1'b0, a} + {1'b0, d[8*k +: 8]};
      a = s[7:0] + {7'b0, s[8]};
    end
    return ~a;
  endfunction

  function automatic logic [63:0] ref_mask(input int n);
    return (n >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  task automatic send_bit(input logic v);
    rx_line = v;
    repeat (BP) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(1'b1);
  endtask

  task automatic run_frame(input logic [5:0] id, input logic [63:0] data, input logic [3:0] len_in,
                           input bit enh_cfg, input bit enh_send, input logic [7:0] sync_b,
                           input bit bad_par, input bit bad_chk, input int brk_bits,
                           input logic [5:0] mid, input logic [63:0] mdata, input string tag);
    int n;
    logic [7:0] pid, cs;
    logic [63:0] dm;
    int v0, s0, p0, k0, i0, d0, b0;
    bit brk_ok, sync_ok, par_ok, good, dhit;
    n = (len_in == 0) ? 1 : ((len_in > 8) ? 8 : int'(len_in));
    dm = data & ref_mask(n);
    pid = ref_pid(id) ^ (bad_par ? 8'h80 : 8'h00);
    cs = ref_sum(enh_send, ref_pid(id), dm, n) ^ (bad_chk ? 8'h01 : 8'h00);
    exp_len = len_in; enhanced_mode = enh_cfg; match_id = mid; match_data = mdata;
    v0 = c_val; s0 = c_sync; p0 = c_par; k0 = c_chk; i0 = c_tid; d0 = c_tdat; b0 = c_tboth;
    repeat (2) send_bit(1'b1);
    repeat (brk_bits) send_bit(1'b0);
    send_bit(1'b1);
    send_byte(sync_b);
    send_byte(pid);
    for (int k = 0; k < n; k++) send_byte(dm[8*k +: 8]);
    send_byte(cs);
    repeat (3) send_bit(1'b1);

    brk_ok  = (brk_bits >= 13);
    sync_ok = brk_ok && (sync_b == 8'h55);
    par_ok  = sync_ok && !bad_par;
    good    = par_ok && (cs == ref_sum(enh_cfg, ref_pid(id), dm, n));
    dhit    = ((dm ^ mdata) & ref_mask(n)) == 64'd0;

    check({"R2 R4 sync err ", tag}, 64'(c_sync - s0), 64'(brk_ok && !sync_ok));
    check({"R5 parity err ", tag}, 64'(c_par - p0), 64'(sync_ok && bad_par));
    check({"R7 R8 frame_valid ", tag}, 64'(c_val - v0), 64'(good));
    check({"R9 checksum err ", tag}, 64'(c_chk - k0), 64'(par_ok && !good));
    check({"R12 one outcome ", tag}, 64'((c_val - v0) + (c_sync - s0) + (c_par - p0) + (c_chk - k0)),
          64'(brk_ok));
    check({"R10 trig_id ", tag}, 64'(c_tid - i0), 64'(par_ok && id == mid));
    check({"R11 trig_data ", tag}, 64'(c_tdat - d0), 64'(good && dhit));
    check({"R11 trig_both ", tag}, 64'(c_tboth - b0), 64'(good && dhit && id == mid));
    if (par_ok) last_id = id;
    check({"R5 frame_id ", tag}, 64'(frame_id), 64'(last_id));
    if (par_ok) begin
      check({"R3 R6 frame_data ", tag}, frame_data, dm);
      check({"R6 byte_count ", tag}, 64'(byte_count), 64'(n));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset frame_id", 64'(frame_id), 64'd0);
    check("R1 reset frame_data", frame_data, 64'd0);
    check("R1 reset byte_count", 64'(byte_count), 64'd0);
    check("R1 reset strobes", 64'({frame_valid, err_sync, err_parity, err_checksum,
                                   trig_id, trig_data, trig_both}), 64'd0);

    run_frame(6'h12, 64'h5A, 4'd1, 0, 0, 8'h55, 0, 0, 13, 6'h12, 64'h5A, "classic 1 byte");
    run_frame(6'h3C, 64'hFFEE_DDCC_BBAA_9988, 4'd8, 1, 1, 8'h55, 0, 0, 14, 6'h00, 64'd0, "enhanced 8 bytes");
    run_frame(6'h05, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8, 0, 0, 8'h55, 0, 0, 14, 6'h05, 64'hFFFF_FFFF_FFFF_FFFF, "carry wrap");
    run_frame(6'h21, 64'h77, 4'd0, 0, 0, 8'h55, 0, 0, 14, 6'h21, 64'h77, "len zero as one");
    run_frame(6'h0A, 64'h0102_0304_0506_0708, 4'd12, 1, 1, 8'h55, 0, 0, 14, 6'h0A, 64'h0102_0304_0506_0708, "len clamp 8");
    run_frame(6'h11, 64'h1234, 4'd2, 0, 0, 8'h54, 0, 0, 14, 6'h11, 64'h1234, "bad sync");
    run_frame(6'h2B, 64'h4321, 4'd2, 0, 0, 8'h55, 1, 0, 14, 6'h2B, 64'h4321, "bad parity");
    run_frame(6'h19, 64'hABCD, 4'd2, 1, 1, 8'h55, 0, 1, 14, 6'h19, 64'hABCD, "bad checksum");
    run_frame(6'h19, 64'hABCD, 4'd2, 1, 0, 8'h55, 0, 0, 14, 6'h19, 64'hABCD, "classic sent enhanced set");
    run_frame(6'h33, 64'h0F0F0F, 4'd3, 0, 1, 8'h55, 0, 0, 14, 6'h33, 64'h0F0F0F, "enhanced sent classic set");
    run_frame(6'h07, 64'h9988, 4'd2, 0, 0, 8'h55, 0, 0, 10, 6'h07, 64'h9988, "short low no break");
    run_frame(6'h07, 64'h9988, 4'd2, 0, 0, 8'h55, 0, 0, 14, 6'h07, 64'h9989, "data miss one bit");
    run_frame(6'h07, 64'h9988, 4'd2, 0, 0, 8'h55, 0, 0, 14, 6'h08, 64'hFF9988, "id miss data hit");

    for (int r = 0; r < 24; r++) begin
      logic [5:0] id, mid;
      logic [63:0] d, md;
      logic [3:0] len;
      bit ec, es, bc;
      id  = 6'($urandom);
      len = 4'(1 + $urandom % 8);
      d   = {$urandom, $urandom};
      ec  = 1'($urandom);
      es  = ($urandom % 8 == 0) ? !ec : ec;
      bc  = ($urandom % 8 == 0);
      mid = ($urandom % 2 == 0) ? id : 6'($urandom);
      md  = ($urandom % 2 == 0) ? d : d ^ (64'd1 << ($urandom % (8 * int'(len))));
      run_frame(id, d, len, ec, es, 8'h55, 0, bc, 13 + $urandom % 3, mid, md, "random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule